// File: doc/BRIEF.md
# ADC Conversion Sequencer with Register Port

This block is the digital half of an analog-to-digital converter. Software programs it through two 32-bit registers on a simple read/write port. The control word picks one of eight input channels and one of two reference levels. It sets a clock divider, enables the converter, starts a conversion and enables the interrupt. A second, read-only word holds the most recent 10-bit result.

A conversion starts when software writes the convert bit from 0 to 1 while the block is enabled. The busy time is a fixed number of prescaled clock periods. During that window a restoring divider computes the selected sample times 1024, divided by the chosen reference, and clamps the result to 1023. At completion the result is stored and the convert bit drops. If the interrupt is enabled, a sticky flag and the interrupt line are also raised. Writing a one to the flag clears both. Samples and reference levels enter as plain digital values.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset the control word reads 0x000C0001, the result word reads 0 and `irq` is low.
- R2: The control word sits at byte offset 0x0 and the result at 0x4. A read of any other offset returns 0, and a write to any other offset changes nothing.
- R3: A write to the result word at 0x4 leaves its contents unchanged.
- R4: The interrupt flag is control bit 18. Writing 1 to bit 18 clears the flag and lowers `irq`. Writing 0 to bit 18 leaves the flag as it was.
- R5: With enable (bit 17) set, a conversion starts only on a write that takes the convert bit (bit 13) from 0 to 1. Writing convert as 1 when it already reads 1 does not restart the timing. Writing it with enable clear starts nothing.
- R6: A conversion completes 20 × 2 × (DIV+1) clock cycles after the starting write, where DIV is control bits 8:1.
- R7: The result is floor(sample × 1024 / ref), clamped to 1023. A zero reference gives 1023. The sample is the channel given by control bits 27:24. Bit 19 = 1 selects `ref_int` and bit 19 = 0 selects `ref_ext`.
- R8: At completion the result word is updated and bit 13 clears. If interrupt enable (bit 21) is set, the flag is set and `irq` rises.
- R9: Writing convert as 0 while enable is set aborts a running conversion, and the result word is not updated.
- R10: A write with soft reset (bit 16) set restores the R1 values, lowers `irq` and aborts any running conversion.
- R11: If the channel field at conversion start is 8 or above, completion leaves the result word and the flag unchanged, and bit 13 stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe, data returned in the same cycle |
| addr | input | ADDR_W (12) | Byte offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data |
| samples | input | NCH*SAMPLE_W (192) | Packed channel samples, channel 0 in the low bits |
| ref_int | input | REF_W (24) | Internal reference level |
| ref_ext | input | REF_W (24) | External reference level |
| irq | output | 1 | Conversion-done interrupt |

## Verification
The bench builds the block with its defaults: eight channels and 24-bit samples and references. With 24-bit samples the divider needs 34 iterations. This is just inside the 40-cycle window that divider setting 0 gives, so every conversion run with that setting tests whether the quotient is ready in time. With eight channels, encodings 8 to 15 are invalid, so the stuck-busy case for an unimplemented channel can be reached. A divider setting of 2 shows that the busy time scales with the divider.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
   // control word field positions (software visible)
   localparam int unsigned CF_CHAN_LSB = 24;
   localparam int unsigned CF_CHAN_W   = 4;
   localparam int unsigned CF_IE       = 21;
   localparam int unsigned CF_REFSEL   = 19;
   localparam int unsigned CF_FLAG     = 18;
   localparam int unsigned CF_EN       = 17;
   localparam int unsigned CF_SRST     = 16;
   localparam int unsigned CF_BUSY     = 13;
   localparam int unsigned CF_DIV_LSB  = 1;
   localparam int unsigned CF_DIV_W    = 8;

   localparam logic [31:0] CTRL_RST_VAL = 32'h000C_0001;
   localparam int unsigned OFS_CTRL = 0;
   localparam int unsigned OFS_DATA = 4;
endpackage

// File: rtl/adc_chan_mux.sv
module adc_chan_mux #(
   parameter int unsigned NCH      = 8,
   parameter int unsigned SAMPLE_W = 24,
   parameter int unsigned SEL_W    = 4
) (
   input  logic [NCH*SAMPLE_W-1:0] samples,
   input  logic [SEL_W-1:0]        sel,
   output logic [SAMPLE_W-1:0]     sample,
   output logic                    valid
);
   logic [SAMPLE_W-1:0] lane [NCH];

   for (genvar g = 0; g < NCH; g++) begin : g_lane
      assign lane[g] = samples[g*SAMPLE_W +: SAMPLE_W];
   end

   always_comb begin
      sample = '0;
      valid  = 1'b0;
      for (int i = 0; i < NCH; i++) begin
         if (sel == SEL_W'(i)) begin
            sample = lane[i];
            valid  = 1'b1;
         end
      end
   end
endmodule

// File: rtl/adc_conv_timer.sv
module adc_conv_timer #(
   parameter int unsigned TICKS = 20,
   parameter int unsigned DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             cancel,
   input  logic [DIV_W-1:0] div,
   output logic             done
);
   localparam int unsigned TICK_W = $clog2(TICKS + 1);
   localparam int unsigned PRE_W  = DIV_W + 1;

   if (TICKS < 1) begin : g_bad_ticks
      $error("adc_conv_timer: TICKS must be at least 1");
   end

   logic              run;
   logic [DIV_W-1:0]  div_q;
   logic [PRE_W-1:0]  pre_cnt;
   logic [TICK_W-1:0] tick_cnt;
   logic              pre_last;

   // one prescaled period is 2*(div+1) clocks, last count 2*div+1
   assign pre_last = (pre_cnt == {div_q, 1'b1});
   assign done     = run && pre_last && (tick_cnt == TICK_W'(TICKS - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run      <= 1'b0;
         div_q    <= '0;
         pre_cnt  <= '0;
         tick_cnt <= '0;
      end else if (start) begin
         run      <= 1'b1;
         div_q    <= div;
         pre_cnt  <= '0;
         tick_cnt <= '0;
      end else if (cancel || done) begin
         run <= 1'b0;
      end else if (run) begin
         if (pre_last) begin
            pre_cnt  <= '0;
            tick_cnt <= tick_cnt + 1'b1;
         end else begin
            pre_cnt <= pre_cnt + 1'b1;
         end
      end
   end
endmodule

// File: rtl/adc_restoring_div.sv
module adc_restoring_div #(
   parameter int unsigned NUM_W = 24,
   parameter int unsigned DEN_W = 24,
   parameter int unsigned RES_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [NUM_W-1:0] num,
   input  logic [DEN_W-1:0] den,
   output logic [RES_W-1:0] result
);
   localparam int unsigned QW    = NUM_W + RES_W;
   localparam int unsigned CNT_W = $clog2(QW + 1);
   localparam logic [RES_W-1:0] MAXV = {RES_W{1'b1}};

   logic [QW-1:0]    quo;
   logic [DEN_W-1:0] rem;
   logic [DEN_W-1:0] den_q;
   logic [CNT_W-1:0] left;
   logic [DEN_W:0]   trial;
   logic             fits;

   assign trial = {rem, quo[QW-1]};
   assign fits  = (trial >= {1'b0, den_q});

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         quo   <= '0;
         rem   <= '0;
         den_q <= '0;
         left  <= '0;
      end else if (start) begin
         quo   <= {num, {RES_W{1'b0}}};
         rem   <= '0;
         den_q <= den;
         left  <= CNT_W'(QW);
      end else if (left != '0) begin
         quo  <= {quo[QW-2:0], fits};
         rem  <= fits ? DEN_W'(trial - {1'b0, den_q}) : DEN_W'(trial);
         left <= left - 1'b1;
      end
   end

   // clamp: zero divisor or any quotient bit above the result width saturates
   assign result = ((den_q == '0) || (|quo[QW-1:RES_W])) ? MAXV : quo[RES_W-1:0];
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
   import adc_seq_pkg::*;
#(
   parameter int unsigned NCH        = 8,
   parameter int unsigned SAMPLE_W   = 24,
   parameter int unsigned REF_W      = 24,
   parameter int unsigned RES_W      = 10,
   parameter int unsigned CONV_TICKS = 20,
   parameter int unsigned ADDR_W     = 12
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_en,
   input  logic                    rd_en,
   input  logic [ADDR_W-1:0]       addr,
   input  logic [31:0]             wdata,
   output logic [31:0]             rdata,
   input  logic [NCH*SAMPLE_W-1:0] samples,
   input  logic [REF_W-1:0]        ref_int,
   input  logic [REF_W-1:0]        ref_ext,
   output logic                    irq
);
   localparam int unsigned DIV_ITERS  = SAMPLE_W + RES_W;
   localparam int unsigned MIN_WINDOW = 2 * CONV_TICKS;

   if (NCH < 1 || NCH > (1 << CF_CHAN_W)) begin : g_bad_nch
      $error("adc_seq_ctrl: NCH out of range of the channel field");
   end
   if (DIV_ITERS > MIN_WINDOW) begin : g_bad_window
      $error("adc_seq_ctrl: divider cannot finish in the shortest conversion");
   end
   if (RES_W > 16 || ADDR_W < 3) begin : g_bad_widths
      $error("adc_seq_ctrl: RES_W or ADDR_W out of range");
   end

   logic [31:0]          ctrl_q, ctrl_mid, ctrl_next;
   logic [31:0]          data_q, data_next;
   logic                 irq_q, irq_mid, irq_next;
   logic                 chan_ok_q;
   logic                 conv_done, conv_start, conv_cancel;
   logic                 sel_ctrl, sel_data, wr_ctrl;
   logic [SAMPLE_W-1:0]  mux_sample;
   logic                 mux_valid;
   logic [REF_W-1:0]     ref_pick;
   logic [RES_W-1:0]     div_res;

   assign sel_ctrl = (addr == ADDR_W'(OFS_CTRL));
   assign sel_data = (addr == ADDR_W'(OFS_DATA));
   assign wr_ctrl  = wr_en && sel_ctrl;

   // operands are taken from the value being written at conversion start
   adc_chan_mux #(.NCH(NCH), .SAMPLE_W(SAMPLE_W), .SEL_W(CF_CHAN_W)) u_mux (
      .samples (samples),
      .sel     (wdata[CF_CHAN_LSB +: CF_CHAN_W]),
      .sample  (mux_sample),
      .valid   (mux_valid)
   );

   assign ref_pick = wdata[CF_REFSEL] ? ref_int : ref_ext;

   adc_restoring_div #(.NUM_W(SAMPLE_W), .DEN_W(REF_W), .RES_W(RES_W)) u_div (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (conv_start),
      .num    (mux_sample),
      .den    (ref_pick),
      .result (div_res)
   );

   adc_conv_timer #(.TICKS(CONV_TICKS), .DIV_W(CF_DIV_W)) u_tmr (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (conv_start),
      .cancel (conv_cancel),
      .div    (wdata[CF_DIV_LSB +: CF_DIV_W]),
      .done   (conv_done)
   );

   // completion is applied first, a same-cycle control write then acts on top of it
   always_comb begin
      ctrl_mid  = ctrl_q;
      irq_mid   = irq_q;
      data_next = data_q;
      if (conv_done && chan_ok_q) begin
         data_next = {{(32-RES_W){1'b0}}, div_res};
         if (ctrl_q[CF_IE]) begin
            ctrl_mid[CF_FLAG] = 1'b1;
            irq_mid           = 1'b1;
         end
         ctrl_mid[CF_BUSY] = 1'b0;
      end

      ctrl_next   = ctrl_mid;
      irq_next    = irq_mid;
      conv_start  = 1'b0;
      conv_cancel = 1'b0;
      if (wr_ctrl) begin
         ctrl_next          = wdata;
         ctrl_next[CF_FLAG] = ctrl_mid[CF_FLAG] & ~wdata[CF_FLAG];
         if (wdata[CF_FLAG]) irq_next = 1'b0;
         if (wdata[CF_SRST]) begin
            ctrl_next   = CTRL_RST_VAL;
            data_next   = '0;
            irq_next    = 1'b0;
            conv_cancel = 1'b1;
         end else if (wdata[CF_EN]) begin
            if (wdata[CF_BUSY] && !ctrl_mid[CF_BUSY]) conv_start  = 1'b1;
            else if (!wdata[CF_BUSY])                 conv_cancel = 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q    <= CTRL_RST_VAL;
         data_q    <= '0;
         irq_q     <= 1'b0;
         chan_ok_q <= 1'b0;
      end else begin
         ctrl_q <= ctrl_next;
         data_q <= data_next;
         irq_q  <= irq_next;
         if (conv_start) chan_ok_q <= mux_valid;
      end
   end

   always_comb begin
      rdata = '0;
      if (rd_en) begin
         if (sel_ctrl)      rdata = ctrl_q;
         else if (sel_data) rdata = data_q;
      end
   end

   assign irq = irq_q;
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk
   import adc_seq_pkg::*;
#(
   parameter int unsigned ADDR_W = 12,
   parameter int unsigned RES_W  = 10
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [ADDR_W-1:0] addr,
   input logic [31:0]       wdata,
   input logic              irq,
   input logic [31:0]       ctrl_q,
   input logic [31:0]       data_q,
   input logic              conv_done,
   input logic              chan_ok_q
);
   logic ctl_wr;
   assign ctl_wr = wr_en && (addr == ADDR_W'(OFS_CTRL));

   // R8: the line is only high while the sticky flag is set
   p_irq_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> ctrl_q[CF_FLAG]);

   // R7: stored result never exceeds the saturation value
   p_data_max_r7: assert property (@(posedge clk) disable iff (!rst_n)
      data_q <= 32'((1 << RES_W) - 1));

   // R3: result word changes only through completion or soft reset
   p_data_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (data_q != $past(data_q)) |-> $past(conv_done || (ctl_wr && wdata[CF_SRST])));

   // R4: a one written to the flag clears flag and line
   p_w1c_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && wdata[CF_FLAG]) |=> (!irq && !ctrl_q[CF_FLAG]));

   // R8: valid completion without a competing write drops busy
   p_busy_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (conv_done && chan_ok_q && !ctl_wr) |=> !ctrl_q[CF_BUSY]);

   // R8: the line rises only from a completion
   p_irq_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(conv_done));
endmodule

bind adc_seq_ctrl adc_seq_chk #(.ADDR_W(ADDR_W), .RES_W(RES_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_en     (wr_en),
   .addr      (addr),
   .wdata     (wdata),
   .irq       (irq),
   .ctrl_q    (ctrl_q),
   .data_q    (data_q),
   .conv_done (conv_done),
   .chan_ok_q (chan_ok_q)
);

// File: tb/adc_seq_ctrl_tb_top.sv
module adc_seq_ctrl_tb_top;
   localparam int NCH = 8;
   localparam int SW  = 24;
   localparam int RW  = 24;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic          rd_en = 1'b0;
   logic [11:0]   addr = '0;
   logic [31:0]   wdata = '0;
   logic [31:0]   rdata;
   logic [NCH*SW-1:0] samples;
   logic [RW-1:0] ref_int, ref_ext;
   logic          irq;

   int n_chk  = 0;
   int n_fail = 0;

   typedef struct { int data; int cycles; string tag; } exp_t;
   exp_t sb_q[$];

   always #10 clk = ~clk;

   adc_seq_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .samples(samples), .ref_int(ref_int),
      .ref_ext(ref_ext), .irq(irq)
   );

   function automatic int samp(int ch);
      return 100000 + ch * 150000;
   endfunction

   function automatic int model(longint s, longint r);
      longint q;
      if (r == 0) return 1023;
      q = (s * 1024) / r;
      return (q > 1023) ? 1023 : int'(q);
   endfunction

   function automatic logic [31:0] mk(int ch, bit ie, bit rs, bit en, bit cv, int dv);
      return (32'(ch) << 24) | (32'(ie) << 21) | (32'(rs) << 19) |
             (32'(en) << 17) | (32'(cv) << 13) | (32'(dv) << 1);
   endfunction

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic bus_wr(logic [11:0] a, logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic bus_rd(logic [11:0] a, output logic [31:0] d);
      addr = a; rd_en = 1'b1;
      #1;
      d = rdata;
      rd_en = 1'b0;
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // driver: issue a start write and push the expected outcome
   task automatic drive_conv(logic [31:0] word, int exp_data, int exp_cyc, string tag);
      exp_t e;
      e.data = exp_data; e.cycles = exp_cyc; e.tag = tag;
      sb_q.push_back(e);
      bus_wr(12'h0, word);
   endtask

   // monitor: count cycles until busy drops, then pop and compare
   task automatic monitor_conv();
      logic [31:0] v;
      int cyc = 0;
      exp_t e;
      bus_rd(12'h0, v);
      while (v[13] && cyc < 5000) begin
         @(negedge clk);
         cyc++;
         bus_rd(12'h0, v);
      end
      e = sb_q.pop_front();
      check({e.tag, " R6 duration"}, 32'(cyc), 32'(e.cycles));
      bus_rd(12'h4, v);
      check({e.tag, " R7 result"}, v, 32'(e.data));
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      logic [31:0] v, w;
      for (int c = 0; c < NCH; c++) samples[c*SW +: SW] = SW'(samp(c));
      ref_int = RW'(2000000);
      ref_ext = RW'(1800000);
      idle(5);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      bus_rd(12'h0, v); check("R1 ctrl", v, 32'h000C0001);
      bus_rd(12'h4, v); check("R1 data", v, 32'h0);
      check("R1 irq", 32'(irq), 32'h0);

      // R2 unmapped read and write
      bus_wr(12'h10, 32'hFFFF_FFFF);
      bus_rd(12'h8, v); check("R2 unmapped read", v, 32'h0);
      bus_rd(12'h0, v); check("R2 ctrl untouched", v, 32'h000C0001);

      // R4 write 0 keeps flag, write 1 clears
      bus_wr(12'h0, 32'h0);
      bus_rd(12'h0, v); check("R4 flag kept", 32'(v[18]), 32'h1);
      bus_wr(12'h0, 32'h0004_0000);
      bus_rd(12'h0, v); check("R4 flag cleared", 32'(v[18]), 32'h0);

      // R6 R7 R8 channel 2, internal reference, interrupt on, DIV 0
      drive_conv(mk(2, 1, 1, 1, 1, 0), model(samp(2), 2000000), 40, "ch2 int");
      monitor_conv();
      bus_rd(12'h0, v);
      check("R8 busy clear", 32'(v[13]), 32'h0);
      check("R8 flag set", 32'(v[18]), 32'h1);
      check("R8 irq high", 32'(irq), 32'h1);

      // R4 flag survives a write of 0, then clears with a 1
      bus_wr(12'h0, mk(2, 1, 1, 1, 0, 0));
      check("R4 irq kept", 32'(irq), 32'h1);
      bus_wr(12'h0, mk(2, 1, 1, 1, 0, 0) | 32'h0004_0000);
      check("R4 irq cleared", 32'(irq), 32'h0);
      bus_rd(12'h0, v); check("R4 flag clear", 32'(v[18]), 32'h0);

      // R6 R7 channel 5, external reference, DIV 2, no interrupt
      drive_conv(mk(5, 0, 0, 1, 1, 2), model(samp(5), 1800000), 120, "ch5 ext");
      monitor_conv();
      check("R8 no irq without enable", 32'(irq), 32'h0);

      // R5 rewriting convert=1 mid conversion does not restart timing
      bus_wr(12'h0, mk(3, 0, 1, 1, 1, 0));
      idle(10);
      drive_conv(mk(3, 0, 1, 1, 1, 0), model(samp(3), 2000000), 28, "R5 rewrite");
      monitor_conv();

      // R5 convert with enable clear, then convert already 1: no start
      bus_wr(12'h0, mk(1, 0, 1, 0, 1, 0));
      idle(60);
      bus_rd(12'h4, v); check("R5 disabled no start", v, 32'(model(samp(3), 2000000)));
      bus_wr(12'h0, mk(1, 0, 1, 1, 1, 0));
      idle(60);
      bus_rd(12'h4, v); check("R5 no edge no start", v, 32'(model(samp(3), 2000000)));
      bus_rd(12'h0, v); check("R5 busy stays", 32'(v[13]), 32'h1);
      bus_wr(12'h0, mk(1, 0, 1, 1, 0, 0));

      // R7 saturation and zero reference
      ref_ext = RW'(1000000);
      drive_conv(mk(7, 0, 0, 1, 1, 0), 1023, 40, "R7 saturate");
      monitor_conv();
      drive_conv(mk(2, 0, 1, 1, 1, 0), model(samp(2), 2000000), 40, "R7 refsel int");
      monitor_conv();
      ref_ext = '0;
      drive_conv(mk(2, 0, 0, 1, 1, 0), 1023, 40, "R7 zero ref");
      monitor_conv();

      // R3 result word is read-only
      bus_wr(12'h4, 32'h0000_0055);
      bus_rd(12'h4, v); check("R3 data write ignored", v, 32'd1023);

      // R9 cancel a running conversion
      bus_wr(12'h0, mk(3, 1, 1, 1, 1, 1));
      idle(20);
      bus_wr(12'h0, mk(3, 1, 1, 1, 0, 1));
      idle(150);
      bus_rd(12'h4, v); check("R9 data unchanged", v, 32'd1023);
      check("R9 no irq", 32'(irq), 32'h0);

      // R11 unimplemented channel
      bus_wr(12'h0, mk(9, 1, 1, 1, 1, 0));
      idle(100);
      bus_rd(12'h4, v); check("R11 data unchanged", v, 32'd1023);
      bus_rd(12'h0, w);
      check("R11 busy stays", 32'(w[13]), 32'h1);
      check("R11 flag unchanged", 32'(w[18]), 32'h0);
      bus_wr(12'h0, mk(9, 1, 1, 1, 0, 0));

      // R10 soft reset during a conversion
      bus_wr(12'h0, mk(2, 1, 1, 1, 1, 0));
      idle(10);
      bus_wr(12'h0, 32'h0001_0000);
      bus_rd(12'h0, v); check("R10 ctrl restored", v, 32'h000C0001);
      bus_rd(12'h4, v); check("R10 data cleared", v, 32'h0);
      idle(100);
      bus_rd(12'h4, v); check("R10 conversion aborted", v, 32'h0);
      check("R10 irq low", 32'(irq), 32'h0);

      finish_run();
   end
endmodule